// File: doc/BRIEF.md
# Control Transfer OUT Status-Stage Sequencer

This block is the device-side sequencer for the OUT status stage of a USB control transfer. It sits behind a packet engine that has already decoded each packet. It receives token events with their kind, address, endpoint and error flag, and data-packet events with the PID parity, payload length and CRC result. From these it decides which handshake the device returns, updates a small status code and raises a completion interrupt.

Three inputs shape the decision. A firmware strobe records that the end-of-packet register has been written. A stall request forces a STALL reply. An enable from the stage-control logic marks that the status stage may run. If firmware has not yet written the end-of-packet register, the block answers NAK so the host retries later. Once the register is written, the block waits a bounded time for a clean zero-length DATA1 packet and then acknowledges it. A fresh SETUP that cuts the stage short is reported as a receive error.

Top module: `ctl_status_out_seq`

## Requirements
- R1: After a synchronous reset, stat_code is 0 (idle), hs_vld and stat_irq are low, and the firmware end-of-packet flag is clear, so a valid OUT token answers NAK.
- R2: A token is accepted only when tok_vld is high, tok_err is low, tok_addr equals cfg_addr and tok_ep equals cfg_ep. tok_kind 0 is OUT and 2 is SETUP. Any other token produces no handshake and no status change.
- R3: An accepted OUT token while stage_en is low produces no handshake and leaves the block idle, so a following data packet is ignored.
- R4: With stall_req high, an accepted OUT token (idle) or a data packet (waiting) gives hs_code 3 (STALL) one cycle later. This takes precedence over NAK and clears the end-of-packet flag.
- R5: An accepted enabled OUT token with the end-of-packet flag clear gives hs_code 2 (NAK) one cycle later, and the block stays idle.
- R6: An accepted enabled OUT token with the flag set moves the block to waiting. A data packet with dat_is_data1 high, dat_len zero and no CRC error then gives, one cycle later, hs_code 1 (ACK), stat_code 1 (ready) and a stat_irq pulse.
- R7: A data packet with a DATA0 PID, a nonzero length or a CRC error produces no handshake, returns the block to idle and leaves stat_code unchanged.
- R8: A data packet is accepted only if it arrives within TMO_CYC cycles after the accepted token. When no packet arrives in that window, the block returns to idle with no handshake.
- R9: An accepted SETUP token, arriving while the block waits or while stage_en is high and the stage has not completed, sets stat_code to 2 (RX error) with no handshake. Any accepted SETUP returns the block to idle and clears the end-of-packet flag.
- R10: An ACK consumes the end-of-packet flag, so the next OUT token without a new eop_wr answers NAK. An eop_wr in the same cycle as a clear wins.
- R11: hs_vld and stat_irq are single-cycle pulses, and hs_code is 0 whenever hs_vld is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | ADDR_W | Device address assigned to this function |
| cfg_ep | input | EP_W | Control endpoint number |
| tok_vld | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 other |
| tok_addr | input | ADDR_W | Token address field |
| tok_ep | input | EP_W | Token endpoint field |
| tok_err | input | 1 | Token CRC or framing error |
| dat_vld | input | 1 | Data packet event strobe |
| dat_is_data1 | input | 1 | High for a DATA1 PID, low for DATA0 |
| dat_len | input | LEN_W | Payload length in bytes |
| dat_crc_err | input | 1 | Data CRC failed |
| eop_wr | input | 1 | Firmware wrote the end-of-packet register |
| stall_req | input | 1 | Stall condition active |
| stage_en | input | 1 | Status stage enabled by stage control |
| hs_vld | output | 1 | Handshake request strobe |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| stat_code | output | 2 | 0 idle, 1 ready, 2 RX error |
| stat_irq | output | 1 | Status interrupt pulse |

## Verification
The hardest state to reach from the ports is the window in which the block is waiting for the data packet. Timeout, a mid-stage SETUP and a stall raised after the token all happen only there. The stimulus first pulses eop_wr, then sends a matching OUT token with stage_en high, and then places the next event an exact number of negative edges later. Counting those edges lets the bench land data on the last accepted cycle of the timeout window and one cycle past it.

// File: rtl/ctl_stat_pkg.sv
package ctl_stat_pkg;

  localparam logic [1:0] TK_OUT   = 2'd0;
  localparam logic [1:0] TK_IN    = 2'd1;
  localparam logic [1:0] TK_SETUP = 2'd2;

  localparam logic [1:0] HS_NONE  = 2'd0;
  localparam logic [1:0] HS_ACK   = 2'd1;
  localparam logic [1:0] HS_NAK   = 2'd2;
  localparam logic [1:0] HS_STALL = 2'd3;

  localparam logic [1:0] SC_IDLE   = 2'd0;
  localparam logic [1:0] SC_READY  = 2'd1;
  localparam logic [1:0] SC_RX_ERR = 2'd2;

  typedef enum logic {S_IDLE, S_WAIT} seq_st_t;

  // A status-stage data packet is clean only as a zero-length DATA1 with good CRC.
  function automatic logic zlp_good(input logic is_d1, input logic len_zero,
                                    input logic crc_err);
    return is_d1 & len_zero & ~crc_err;
  endfunction

endpackage

// File: rtl/ctl_tok_filter.sv
module ctl_tok_filter #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4
) (
  input  logic              tok_vld,
  input  logic [1:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_err,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [EP_W-1:0]   cfg_ep,
  output logic              out_hit,
  output logic              setup_hit
);
  import ctl_stat_pkg::*;

  logic for_us;

  always_comb begin
    for_us    = tok_vld && !tok_err && (tok_addr == cfg_addr) && (tok_ep == cfg_ep);
    out_hit   = for_us && (tok_kind == TK_OUT);
    setup_hit = for_us && (tok_kind == TK_SETUP);
  end

endmodule

// File: rtl/ctl_eop_flag.sv
module ctl_eop_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  p_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);

endmodule

// File: rtl/ctl_resp_timer.sv
module ctl_resp_timer #(
  parameter int TMO_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_comb expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_expire_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == '0));

endmodule

// File: rtl/ctl_status_out_seq.sv
module ctl_status_out_seq #(
  parameter int ADDR_W  = 7,
  parameter int EP_W    = 4,
  parameter int LEN_W   = 11,
  parameter int TMO_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              tok_vld,
  input  logic [1:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_err,
  input  logic              dat_vld,
  input  logic              dat_is_data1,
  input  logic [LEN_W-1:0]  dat_len,
  input  logic              dat_crc_err,
  input  logic              eop_wr,
  input  logic              stall_req,
  input  logic              stage_en,
  output logic              hs_vld,
  output logic [1:0]        hs_code,
  output logic [1:0]        stat_code,
  output logic              stat_irq
);
  import ctl_stat_pkg::*;

  // Named internal events, visible to the assertions.
  logic    out_hit, setup_hit, eop_q, tmr_expire, stage_done;
  logic    eop_clr, done_set, setup_abort, dat_good;
  seq_st_t st, st_n;
  logic       hs_vld_n, irq_n;
  logic [1:0] hs_n, stat_n;

  ctl_tok_filter #(.ADDR_W(ADDR_W), .EP_W(EP_W)) u_filt (
    .tok_vld(tok_vld), .tok_kind(tok_kind), .tok_addr(tok_addr),
    .tok_ep(tok_ep), .tok_err(tok_err), .cfg_addr(cfg_addr),
    .cfg_ep(cfg_ep), .out_hit(out_hit), .setup_hit(setup_hit));

  ctl_eop_flag u_eop (
    .clk(clk), .rst(rst), .set(eop_wr), .clr(eop_clr), .q(eop_q));

  ctl_resp_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(st == S_WAIT), .expire(tmr_expire));

  always_comb begin
    dat_good    = zlp_good(dat_is_data1, dat_len == '0, dat_crc_err);
    setup_abort = setup_hit && ((st == S_WAIT) || (stage_en && !stage_done));
  end

  always_comb begin
    st_n     = st;
    hs_vld_n = 1'b0;
    hs_n     = HS_NONE;
    stat_n   = stat_code;
    irq_n    = 1'b0;
    eop_clr  = 1'b0;
    done_set = 1'b0;
    if (setup_hit) begin
      st_n    = S_IDLE;
      eop_clr = 1'b1;
      if (setup_abort) stat_n = SC_RX_ERR;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (out_hit && stage_en) begin
            if (stall_req) begin
              hs_vld_n = 1'b1;
              hs_n     = HS_STALL;
              eop_clr  = 1'b1;
            end else if (!eop_q) begin
              hs_vld_n = 1'b1;
              hs_n     = HS_NAK;
            end else begin
              st_n = S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (dat_vld) begin
            st_n = S_IDLE;
            if (stall_req) begin
              hs_vld_n = 1'b1;
              hs_n     = HS_STALL;
              eop_clr  = 1'b1;
            end else if (dat_good) begin
              hs_vld_n = 1'b1;
              hs_n     = HS_ACK;
              stat_n   = SC_READY;
              irq_n    = 1'b1;
              eop_clr  = 1'b1;
              done_set = 1'b1;
            end
          end else if (tmr_expire) begin
            st_n = S_IDLE;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      hs_vld     <= 1'b0;
      hs_code    <= HS_NONE;
      stat_code  <= SC_IDLE;
      stat_irq   <= 1'b0;
      stage_done <= 1'b0;
    end else begin
      st        <= st_n;
      hs_vld    <= hs_vld_n;
      hs_code   <= hs_n;
      stat_code <= stat_n;
      stat_irq  <= irq_n;
      if (setup_hit)     stage_done <= 1'b0;
      else if (done_set) stage_done <= 1'b1;
    end
  end

  p_irq_ack_r6: assert property (@(posedge clk) disable iff (rst)
    stat_irq |-> (hs_vld && hs_code == HS_ACK && stat_code == SC_READY));
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    stat_irq |=> !stat_irq);
  p_code_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !hs_vld |-> (hs_code == HS_NONE));
  p_nak_noflag_r5: assert property (@(posedge clk) disable iff (rst)
    (hs_vld && hs_code == HS_NAK) |-> !$past(eop_q));
  p_wait_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && $past(st) == S_IDLE) |-> $past(eop_q));
  p_rxerr_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_code == SC_RX_ERR && $past(stat_code) != SC_RX_ERR) |-> $past(setup_hit));
  p_timeout_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (tmr_expire && !dat_vld && !setup_hit) |=> (st == S_IDLE && !hs_vld));

endmodule

// File: tb/sim_ctl_status_out_seq.sv
module sim_ctl_status_out_seq;

  localparam int TMO = 16;
  localparam logic [6:0] MYADDR = 7'h2A;

  logic clk = 1'b0, rst = 1'b1;
  logic [6:0] cfg_addr = MYADDR, tok_addr = '0;
  logic [3:0] cfg_ep = 4'h0, tok_ep = '0;
  logic tok_vld = 0, tok_err = 0, dat_vld = 0, dat_is_data1 = 0, dat_crc_err = 0;
  logic [1:0] tok_kind = '0;
  logic [10:0] dat_len = '0;
  logic eop_wr = 0, stall_req = 0, stage_en = 0;
  logic hs_vld, stat_irq;
  logic [1:0] hs_code, stat_code;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ctl_status_out_seq #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_ep(cfg_ep),
    .tok_vld(tok_vld), .tok_kind(tok_kind), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .tok_err(tok_err), .dat_vld(dat_vld), .dat_is_data1(dat_is_data1),
    .dat_len(dat_len), .dat_crc_err(dat_crc_err), .eop_wr(eop_wr),
    .stall_req(stall_req), .stage_en(stage_en), .hs_vld(hs_vld),
    .hs_code(hs_code), .stat_code(stat_code), .stat_irq(stat_irq));

  // Vector: en stl eop abad terr d1 lenz crc | hs after token {vld,code} | hs after data
  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    14'b1_0_1_0_0_1_1_0_000_101,  // clean stage -> ACK       R6
    14'b1_0_0_0_0_1_1_0_110_000,  // no eop write -> NAK      R5
    14'b1_1_1_0_0_1_1_0_111_000,  // stall at token            R4
    14'b0_0_1_0_0_1_1_0_000_000,  // stage disabled            R3
    14'b1_0_1_1_0_1_1_0_000_000,  // wrong address             R2
    14'b1_0_1_0_1_1_1_0_000_000,  // token error               R2
    14'b1_0_1_0_0_0_1_0_000_000,  // DATA0 PID                 R7
    14'b1_0_1_0_0_1_0_0_000_000,  // nonzero length            R7
    14'b1_0_1_0_0_1_1_1_000_000,  // CRC error                 R7
    14'b1_1_0_0_0_1_1_0_111_000   // stall beats NAK           R4
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_eop();
    eop_wr = 1'b1;
    @(negedge clk);
    eop_wr = 1'b0;
  endtask

  task automatic send_tok(input logic [1:0] kind, input logic [6:0] a,
                          input logic [3:0] ep, input logic err);
    tok_vld = 1'b1; tok_kind = kind; tok_addr = a; tok_ep = ep; tok_err = err;
    @(negedge clk);
    tok_vld = 1'b0; tok_err = 1'b0;
  endtask

  task automatic send_dat(input logic d1, input logic [10:0] len, input logic crc);
    dat_vld = 1'b1; dat_is_data1 = d1; dat_len = len; dat_crc_err = crc;
    @(negedge clk);
    dat_vld = 1'b0; dat_crc_err = 1'b0;
  endtask

  function automatic int hs_obs();
    return {29'd0, hs_vld, hs_code};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 stat", stat_code, 0);
    chk("R1 hs", hs_obs(), 0);
    chk("R1 irq", stat_irq, 0);
    stage_en = 1'b1;
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    chk("R1 flag clear -> NAK", hs_obs(), 6);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      do_reset();
      stage_en = v[13]; stall_req = v[12];
      if (v[11]) pulse_eop();
      send_tok(2'd0, v[10] ? MYADDR + 7'd1 : MYADDR, 4'h0, v[9]);
      chk($sformatf("R2-6 vec%0d token hs", i), hs_obs(), int'(v[5:3]));
      send_dat(v[8], v[7] ? 11'd0 : 11'd3, v[6]);
      chk($sformatf("R4-7 vec%0d data hs", i), hs_obs(), int'(v[2:0]));
      chk($sformatf("R6 vec%0d stat", i), stat_code, (v[2:0] == 3'b101) ? 1 : 0);
      chk($sformatf("R6 vec%0d irq", i), stat_irq, (v[2:0] == 3'b101) ? 1 : 0);
      stall_req = 1'b0;
    end

    // R10 / R11: ACK consumes flag; pulses last one cycle
    do_reset(); stage_en = 1'b1;
    pulse_eop();
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    send_dat(1'b1, 11'd0, 1'b0);
    chk("R6 ack", hs_obs(), 5);
    @(negedge clk);
    chk("R11 hs drops", hs_obs(), 0);
    chk("R11 irq drops", stat_irq, 0);
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    chk("R10 flag consumed -> NAK", hs_obs(), 6);

    // R2: endpoint mismatch
    do_reset(); stage_en = 1'b1;
    send_tok(2'd0, MYADDR, 4'h1, 1'b0);
    chk("R2 ep mismatch", hs_obs(), 0);

    // R8: last accepted cycle
    do_reset(); stage_en = 1'b1;
    pulse_eop();
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    repeat (TMO - 1) @(negedge clk);
    send_dat(1'b1, 11'd0, 1'b0);
    chk("R8 in window", hs_obs(), 5);

    // R8: one cycle late
    do_reset(); stage_en = 1'b1;
    pulse_eop();
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    repeat (TMO) @(negedge clk);
    send_dat(1'b1, 11'd0, 1'b0);
    chk("R8 timed out hs", hs_obs(), 0);
    chk("R8 timed out stat", stat_code, 0);

    // R9: SETUP while waiting
    do_reset(); stage_en = 1'b1;
    pulse_eop();
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    send_tok(2'd2, MYADDR, 4'h0, 1'b0);
    chk("R9 setup hs", hs_obs(), 0);
    chk("R9 rx err", stat_code, 2);
    send_dat(1'b1, 11'd0, 1'b0);
    chk("R9 back to idle", hs_obs(), 0);
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    chk("R9 flag cleared -> NAK", hs_obs(), 6);

    // R9: SETUP while idle, stage disabled vs enabled
    do_reset(); stage_en = 1'b0;
    send_tok(2'd2, MYADDR, 4'h0, 1'b0);
    chk("R9 setup stage off", stat_code, 0);
    stage_en = 1'b1;
    send_tok(2'd2, MYADDR, 4'h0, 1'b0);
    chk("R9 setup stage pending", stat_code, 2);

    // R4: stall raised while waiting, flag consumed
    do_reset(); stage_en = 1'b1;
    pulse_eop();
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    stall_req = 1'b1;
    send_dat(1'b1, 11'd0, 1'b0);
    chk("R4 stall at data", hs_obs(), 7);
    stall_req = 1'b0;
    send_tok(2'd0, MYADDR, 4'h0, 1'b0);
    chk("R4 stall cleared flag", hs_obs(), 6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule